// File: doc/BRIEF.md
# Comma-Aligned Serial-to-Word Deserializer

This block rebuilds 10-bit code groups from a retimed serial stream that arrives one bit per bit clock. Every bit clock it slides a ten-bit window over the most recent bits. When the oldest seven bits of that window form the positive-disparity comma, it reports the hit. If realignment is allowed, it moves its word boundary so that the comma becomes a word of its own. Between commas a free-running frame counter closes a word every ten bit clocks.

The serial source is the line input or an internal wrap path, chosen by a loopback select. A signal-valid input stands in for an analog amplitude detector. While it is low, the block reports no signal, emits only all-ones words and ignores commas. A byte-sync enable freezes the boundary for links that align words by other means. After reset the boundary is arbitrary until the first comma arrives.

Top module: `comma_deser`

## Requirements
- R1: Bits are packed in arrival order: among the ten bits that make up a word, the earliest received lands in `word_out[0]` and the latest in `word_out[9]`.
- R2: A comma is a window whose bits 0..6 read 0,0,1,1,1,1,1 (bit 0 earliest) with bits 7..9 ignored. `comma_hit` is high for exactly the one cycle after the clock edge at which the window holding the comma is evaluated.
- R3: The bit-inverted pattern 1,1,0,0,0,0,0 never raises `comma_hit` and never moves the boundary.
- R4: With `sync_en` high, a comma found off the current boundary is emitted at once as a word, and the next words follow at ten-bit spacing from it.
- R5: `word_vld` pulses for one cycle per word. With no realignment, pulses are exactly ten cycles apart, and the first comes after the tenth clock edge following reset release. `word_out` holds its value between pulses.
- R6: With `sync_en` low the boundary never moves: pulses stay ten cycles apart even across a comma, while `comma_hit` still pulses.
- R7: The serial source is `ser_in` when `loop_sel` is 0 and `wrap_in` when it is 1.
- R8: `sig_det` equals `sig_ok` from the previous clock edge. A word closed while `sig_ok` is low reads 10'h3FF, and no comma is reported then.
- R9: During reset `word_out` is 10'h3FF and `word_vld`, `comma_hit` and `sig_det` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Line serial bit |
| wrap_in | input | 1 | Internal wrap serial bit |
| loop_sel | input | 1 | 1 selects the wrap path |
| sync_en | input | 1 | 1 allows comma realignment |
| sig_ok | input | 1 | Amplitude-valid indication |
| word_out | output | 10 | Recovered code group, bit 0 earliest |
| word_vld | output | 1 | One-cycle strobe per word |
| comma_hit | output | 1 | One-cycle comma report |
| sig_det | output | 1 | Registered signal-detect status |

## Verification
The checker watches the following on every cycle:
- `word_vld` is never late, and keeps exact ten-cycle spacing whenever realignment is off.
- A reported comma that closes a word carries the comma pattern in its low seven bits.
- A comma with realignment on always closes a word.
- Signal loss forces all-ones words, silences comma reports and delays `sig_det` by exactly one cycle.

Only the bench's scenarios can show the rest:
- Bit order in the word.
- That the inverse pattern is ignored.
- Where the boundary lands after a comma at each possible offset.
- That the loopback select really picks the other source.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;

  typedef enum logic {
    SRC_LINE = 1'b0,
    SRC_WRAP = 1'b1
  } src_e;

  function automatic src_e src_pick(input logic loop);
    return loop ? SRC_WRAP : SRC_LINE;
  endfunction

endpackage

// File: rtl/cd_src_mux.sv
module cd_src_mux
  import comma_deser_pkg::*;
(
  input  logic line_bit,
  input  logic wrap_bit,
  input  src_e src,
  output logic bit_o
);

  always_comb begin
    unique case (src)
      SRC_WRAP: bit_o = wrap_bit;
      default:  bit_o = line_bit;
    endcase
  end

endmodule

// File: rtl/cd_window.sv
module cd_window #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_bit,
  output logic [W-1:0] win
);

  // newest bit enters at the top, so win[0] is the earliest of the last W bits
  function automatic logic [W-1:0] shift_in(input logic [W-1:0] cur, input logic b);
    return {b, cur[W-1:1]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= '0;
    else        win <= shift_in(win, in_bit);
  end

endmodule

// File: rtl/cd_comma_det.sv
module cd_comma_det #(
  parameter int          W   = 10,
  parameter int          PW  = 7,
  parameter logic [PW-1:0] PAT = 7'b1111100
) (
  input  logic [W-1:0] win,
  input  logic         en,
  output logic         hit
);

  function automatic logic is_pat(input logic [W-1:0] v);
    return v[PW-1:0] == PAT;
  endfunction

  assign hit = en && is_pat(win);

endmodule

// File: rtl/cd_frame_ctl.sv
module cd_frame_ctl #(
  parameter int W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic comma_seen,
  input  logic sync_en,
  output logic word_end,
  output logic realign
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic          full;

  function automatic logic [CW-1:0] next_cnt(input logic [CW-1:0] c, input logic restart);
    return restart ? '0 : c + 1'b1;
  endfunction

  assign full     = (cnt == LAST);
  assign realign  = sync_en && comma_seen && !full;
  assign word_end = full || realign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_cnt(cnt, word_end);
  end

endmodule

// File: rtl/comma_deser.sv
module comma_deser
  import comma_deser_pkg::*;
#(
  parameter int            W   = 10,
  parameter int            PW  = 7,
  parameter logic [PW-1:0] PAT = 7'b1111100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         wrap_in,
  input  logic         loop_sel,
  input  logic         sync_en,
  input  logic         sig_ok,
  output logic [W-1:0] word_out,
  output logic         word_vld,
  output logic         comma_hit,
  output logic         sig_det
);

  localparam logic [W-1:0] LOST_WORD = '1;

  logic         sel_bit;
  logic [W-1:0] win;
  logic         comma_seen;
  logic         word_end;
  logic         realign;

  function automatic logic [W-1:0] out_word(input logic [W-1:0] w, input logic ok);
    return ok ? w : LOST_WORD;
  endfunction

  cd_src_mux u_src (
    .line_bit (ser_in),
    .wrap_bit (wrap_in),
    .src      (src_pick(loop_sel)),
    .bit_o    (sel_bit)
  );

  cd_window #(.W(W)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_bit (sel_bit),
    .win    (win)
  );

  cd_comma_det #(.W(W), .PW(PW), .PAT(PAT)) u_det (
    .win (win),
    .en  (sig_ok),
    .hit (comma_seen)
  );

  cd_frame_ctl #(.W(W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .comma_seen (comma_seen),
    .sync_en    (sync_en),
    .word_end   (word_end),
    .realign    (realign)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out  <= LOST_WORD;
      word_vld  <= 1'b0;
      comma_hit <= 1'b0;
      sig_det   <= 1'b0;
    end else begin
      word_vld  <= word_end;
      comma_hit <= comma_seen;
      sig_det   <= sig_ok;
      if (word_end) word_out <= out_word(win, sig_ok);
    end
  end

endmodule

// File: rtl/comma_deser_chk.sv
module comma_deser_chk #(
  parameter int            W   = 10,
  parameter int            PW  = 7,
  parameter logic [PW-1:0] PAT = 7'b1111100
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sync_en,
  input logic         sig_ok,
  input logic [W-1:0] word_out,
  input logic         word_vld,
  input logic         comma_hit,
  input logic         sig_det
);

  localparam int GW = $clog2(W + 1) + 1;
  localparam logic [GW-1:0] GMAX = '1;

  logic [GW-1:0] gap;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap   <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (word_vld)         gap <= GW'(1);
      else if (gap != GMAX) gap <= gap + 1'b1;
    end
  end

  // R5
  vld_not_late_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (gap >= GW'(W)) |-> word_vld);

  // R6
  fixed_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (word_vld && !$past(sync_en)) |-> (gap == GW'(W)));

  // R4
  comma_closes_word_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (comma_hit && $past(sync_en)) |-> word_vld);

  // R2
  comma_content_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (comma_hit && word_vld) |-> (word_out[PW-1:0] == PAT));

  // R8
  lost_ones_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (word_vld && !sig_det) |-> (word_out == '1));

  // R8
  lost_no_comma_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !sig_det |-> !comma_hit);

  // R8
  det_delay_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    sig_det == $past(sig_ok));

endmodule

bind comma_deser comma_deser_chk #(.W(W), .PW(PW), .PAT(PAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_en   (sync_en),
  .sig_ok    (sig_ok),
  .word_out  (word_out),
  .word_vld  (word_vld),
  .comma_hit (comma_hit),
  .sig_det   (sig_det)
);

// File: tb/comma_deser_bench.sv
module comma_deser_bench;

  localparam logic [9:0] KPOS = 10'h17C;
  localparam logic [9:0] KINV = 10'h283;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0, wrap_in = 1'b0, loop_sel = 1'b0, sync_en = 1'b1, sig_ok = 1'b1;
  logic [9:0] word_out;
  logic       word_vld, comma_hit, sig_det;

  int n_tests = 0;
  int n_fail = 0;

  // bench reference state
  logic [9:0] m_win = '0;
  int         m_cnt = 0;
  logic [9:0] e_word = '1;
  logic       e_vld = 0, e_hit = 0, e_det = 0;
  logic [9:0] last_word = '1;
  int         hits = 0;
  int         bad_ones = 0;
  int         b_gap = 0;

  always #2.5 clk = ~clk;

  comma_deser u_comma_deser (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .wrap_in(wrap_in),
    .loop_sel(loop_sel), .sync_en(sync_en), .sig_ok(sig_ok),
    .word_out(word_out), .word_vld(word_vld), .comma_hit(comma_hit), .sig_det(sig_det)
  );

  function automatic logic is_comma_b(input logic [9:0] v);
    return (v[0] == 1'b0) && (v[1] == 1'b0) && (v[6:2] == 5'b11111);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic b, input string tag);
    logic cm, fin;
    if (loop_sel) begin wrap_in = b; ser_in = ~b; end
    else begin ser_in = b; wrap_in = 1'($urandom); end
    @(posedge clk);
    cm  = sig_ok && is_comma_b(m_win);
    fin = (m_cnt == 9) || (sync_en && cm);
    e_vld = fin;
    if (fin) e_word = sig_ok ? m_win : 10'h3FF;
    e_hit = cm;
    e_det = sig_ok;
    m_cnt = fin ? 0 : m_cnt + 1;
    m_win = {b, m_win[9:1]};
    @(negedge clk);
    chk(word_vld === e_vld, "R5 word_vld", 32'(word_vld), 32'(e_vld));
    if (e_vld) chk(word_out === e_word, tag, 32'(word_out), 32'(e_word));
    chk(comma_hit === e_hit, "R2 comma_hit", 32'(comma_hit), 32'(e_hit));
    chk(sig_det === e_det, "R8 sig_det", 32'(sig_det), 32'(e_det));
    if (comma_hit) hits++;
    if (word_vld) begin
      last_word = word_out;
      if (word_out != 10'h3FF) bad_ones++;
      if (!sync_en) chk(b_gap == 9, "R6 spacing", 32'(b_gap + 1), 32'd10);
      b_gap = 0;
    end else b_gap++;
  endtask

  task automatic send_word(input logic [9:0] w, input string tag);
    for (int i = 0; i < 10; i++) step(w[i], tag);
  endtask

  task automatic send_bits(input logic [9:0] v, input int n, input string tag);
    for (int i = 0; i < n; i++) step(v[i], tag);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int h0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(word_out === 10'h3FF, "R9 word_out", 32'(word_out), 32'h3FF);
    chk(word_vld === 1'b0, "R9 word_vld", 32'(word_vld), 0);
    chk(comma_hit === 1'b0, "R9 comma_hit", 32'(comma_hit), 0);
    chk(sig_det === 1'b0, "R9 sig_det", 32'(sig_det), 0);
    rst_n = 1'b1;

    // R4 off-boundary comma, then R1 bit order
    h0 = hits;
    send_bits(10'b101, 3, "R4");
    send_word(KPOS, "R4");
    send_word(10'h001, "R1");
    send_word(10'h2AA, "R1");
    chk(last_word === 10'h001, "R1 order", 32'(last_word), 32'h001);
    chk(hits == h0 + 1, "R2 count", 32'(hits - h0), 1);

    // R3 inverse pattern ignored
    h0 = hits;
    send_bits(10'b011, 3, "R3");
    send_word(KINV, "R3");
    send_word(10'h2AA, "R3");
    send_word(10'h2AA, "R3");
    chk(hits == h0, "R3 no hit", 32'(hits - h0), 0);

    // R6 realign disabled
    sync_en = 1'b0;
    h0 = hits;
    send_bits(10'b1101, 4, "R6");
    send_word(KPOS, "R6");
    send_word(10'h155, "R6");
    send_word(10'h2AA, "R6");
    chk(hits == h0 + 1, "R6 hit still", 32'(hits - h0), 1);
    sync_en = 1'b1;

    // R7 loopback source
    loop_sel = 1'b1;
    send_bits(10'b11, 2, "R7");
    send_word(KPOS, "R7");
    send_word(10'h155, "R7");
    send_word(10'h2AA, "R7");
    chk(last_word === 10'h155, "R7 wrap data", 32'(last_word), 32'h155);
    loop_sel = 1'b0;

    // R8 signal loss
    sig_ok = 1'b0;
    step(1'b0, "R8");
    bad_ones = 0;
    h0 = hits;
    send_word(KPOS, "R8");
    for (int i = 0; i < 40; i++) step(1'($urandom), "R8");
    chk(bad_ones == 0, "R8 forced ones", 32'(bad_ones), 0);
    chk(hits == h0, "R8 no comma", 32'(hits - h0), 0);
    sig_ok = 1'b1;

    // R4 comma at every offset, random data
    for (int it = 0; it < 150; it++) begin
      send_bits(10'($urandom), it % 10, "R4");
      send_word(KPOS, "R4");
      send_word(10'($urandom), "R4");
      send_word(10'($urandom), "R4");
    end

    // mixed random controls
    for (int blk = 0; blk < 80; blk++) begin
      sync_en  = 1'($urandom);
      loop_sel = 1'($urandom);
      sig_ok   = ($urandom % 4) != 0;
      for (int i = 0; i < 50; i++) begin
        if (($urandom % 16) == 0) send_word(KPOS, "R4");
        else step(1'($urandom), "R1");
      end
    end
    finish_run();
  end

endmodule